// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

Two independent register ports, side A and side B, use this block to send each other short messages and interrupts. Each side owns four 16-bit outgoing mailboxes. It can fill them one byte lane at a time. When a side writes the upper byte lane of one of its mailboxes, a pending bit is raised at the opposite side. The receiver reads the message through a peer window in its own address space. A read of the upper lane through that window retires the pending bit.

Each side has its own mask register, which filters pending sources before they reach that side's interrupt line. A cause register records which unmasked sources fired. A status register shows every pending source, whether masked or not. Both views are readable at fixed offsets.

An access counts only when the active-low mailbox strobe is low and the active-low memory enable is held high. Any other combination leaves the block untouched.

Top module: `mbx_dual_irq`

## Requirements
- R1: An access takes effect only when the side's `mbx_sel_n` is 0 and `mem_en_n` is 1. With any other combination, a write changes nothing and a read returns 0 in `rdata`.
- R2: Offsets 0..3 write the side's own mailbox k. Each set bit of `be` writes its byte lane (bit 0 is bits 7:0, bit 1 is bits 15:8). Reading offset k returns the whole word. Offsets 8..11 read the opposite side's mailbox k. No read ever changes mailbox contents.
- R3: A write to own mailbox k with `be[1]`=1 sets pending source k at the opposite side. A write with only `be[0]` sets nothing.
- R4: A side reading back its own mailbox (offsets 0..3) leaves the opposite side's pending bits unchanged.
- R5: A read at offset 8+k with `be[1]`=1 clears the reader's pending source k. The same read with `be[1]`=0 clears nothing.
- R6: Offset 4 is the side's mask. Bits 3:0 are written from `wdata[3:0]` when `be[0]`=1, and 1 means masked. A side can change only its own mask.
- R7: Offset 5 is the cause register. Bit k goes to 1 when source k is set while unmasked, and goes to 0 when source k is cleared. A set that arrives while masked does not update it.
- R8: Offset 6 is the status register. It returns the pending bits of that side, whatever the mask holds.
- R9: `irq` is registered and active-high. After every clock edge it equals the OR over k of pending[k] AND NOT mask[k], using the values updated at that same edge.
- R10: If a set and a clear reach the same source in the same cycle, the source ends up pending.
- R11: `rdata` is registered. It holds the addressed value in the cycle after a read and 0 after any cycle without a read. Writes to offsets 5, 6, 7 and 8..15 are ignored. When `rd` and `wr` are both high, only the write happens.
- R12: Synchronous active-high `rst` clears all mailboxes, pending bits, causes, masks, `irq` and `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_mem_en_n | input | 1 | Side A memory enable, active low; must be 1 for a mailbox access |
| a_mbx_sel_n | input | 1 | Side A mailbox strobe, active low |
| a_rd | input | 1 | Side A read request |
| a_wr | input | 1 | Side A write request |
| a_addr | input | 4 | Side A register offset |
| a_be | input | 2 | Side A byte-lane enables |
| a_wdata | input | 16 | Side A write data |
| a_rdata | output | 16 | Side A registered read data |
| a_irq | output | 1 | Side A interrupt, active high |
| b_mem_en_n | input | 1 | Side B memory enable, active low; must be 1 for a mailbox access |
| b_mbx_sel_n | input | 1 | Side B mailbox strobe, active low |
| b_rd | input | 1 | Side B read request |
| b_wr | input | 1 | Side B write request |
| b_addr | input | 4 | Side B register offset |
| b_be | input | 2 | Side B byte-lane enables |
| b_wdata | input | 16 | Side B write data |
| b_rdata | output | 16 | Side B registered read data |
| b_irq | output | 1 | Side B interrupt, active high |

## Verification
The assertions rely on a few properties of the inputs. `rst` is held for at least one clock before any access. All inputs are driven to 0 or 1 and never left floating. The checks on the pending and cause registers compare each edge with the set and clear vectors of the previous cycle, so they assume those inputs are sampled cleanly at the edge. The stimulus meets these conditions by changing every input only at the falling clock edge and driving defined levels throughout. It also deliberately drives the awkward cases: a strobe while `mem_en_n` is low, a read and a write together, and a set that collides with a clear on the same source.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Fixed register offsets inside each side's mailbox space
  localparam int unsigned OFS_MASK  = 4;
  localparam int unsigned OFS_CAUSE = 5;
  localparam int unsigned OFS_STAT  = 6;
  localparam int unsigned OFS_PEER  = 8;
endpackage

// File: rtl/mbx_outbox.sv
module mbx_outbox #(
  parameter int DW   = 16,
  parameter int NBOX = 4,
  localparam int NB  = DW / 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NBOX-1:0]           box_sel,
  input  logic [NB-1:0]             be,
  input  logic [DW-1:0]             wdata,
  output logic [NBOX-1:0][DW-1:0]   box_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      box_q <= '0;
    end else begin
      for (int k = 0; k < NBOX; k++) begin
        for (int b = 0; b < NB; b++) begin
          if (box_sel[k] && be[b]) box_q[k][b*8 +: 8] <= wdata[b*8 +: 8];
        end
      end
    end
  end

  // Contents move only on a write strobe; reads never disturb them
  assert_box_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(|box_sel) |=> $stable(box_q));
endmodule

// File: rtl/mbx_intr.sv
module mbx_intr #(
  parameter int DW   = 16,
  parameter int NBOX = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NBOX-1:0] set_src,
  input  logic [NBOX-1:0] clr_src,
  input  logic            mask_wr,
  input  logic [DW-1:0]   wdata,
  output logic [NBOX-1:0] mask_q,
  output logic [NBOX-1:0] pend_q,
  output logic [NBOX-1:0] cause_q,
  output logic            irq_q
);
  logic [NBOX-1:0] pend_d, mask_d, cause_d;

  always_comb begin
    pend_d  = (pend_q & ~clr_src) | set_src;
    mask_d  = mask_wr ? wdata[NBOX-1:0] : mask_q;
    cause_d = (cause_q & ~clr_src) | (set_src & ~mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      mask_q  <= '0;
      cause_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      mask_q  <= mask_d;
      cause_q <= cause_d;
      irq_q   <= |(pend_d & ~mask_d);
    end
  end

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (|set_src) |=> ((pend_q & $past(set_src)) == $past(set_src)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (|(clr_src & ~set_src)) |=> ((pend_q & $past(clr_src & ~set_src)) == '0));

  assert_masked_no_cause_R7: assert property (@(posedge clk) disable iff (rst)
    (|(set_src & mask_q & ~cause_q)) |=>
      ((cause_q & $past(set_src & mask_q & ~cause_q)) == '0));

  assert_cause_in_pend_R7: assert property (@(posedge clk) disable iff (rst)
    (cause_q & ~pend_q) == '0);

  assert_irq_align_R9: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(pend_q & ~mask_q));
endmodule

// File: rtl/mbx_port_io.sv
module mbx_port_io
  import mbx_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NBOX = 4,
  parameter int AW   = 4,
  localparam int NB  = DW / 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mem_en_n,
  input  logic                    sel_n,
  input  logic                    rd,
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [NB-1:0]           be,
  input  logic [NBOX-1:0][DW-1:0] own_box,
  input  logic [NBOX-1:0][DW-1:0] peer_box,
  input  logic [NBOX-1:0]         mask,
  input  logic [NBOX-1:0]         cause,
  input  logic [NBOX-1:0]         pend,
  output logic [NBOX-1:0]         box_sel,
  output logic [NBOX-1:0]         raise_peer,
  output logic [NBOX-1:0]         clr_own,
  output logic                    mask_wr,
  output logic [DW-1:0]           rdata
);
  logic          acc, do_wr, do_rd;
  logic [DW-1:0] rd_mux;

  assign acc   = mem_en_n & ~sel_n;
  assign do_wr = acc & wr;
  assign do_rd = acc & rd & ~wr;

  always_comb begin
    mask_wr = do_wr && (addr == AW'(OFS_MASK)) && be[0];
    for (int k = 0; k < NBOX; k++) begin
      box_sel[k]    = do_wr && (addr == AW'(k));
      raise_peer[k] = do_wr && (addr == AW'(k)) && be[NB-1];
      clr_own[k]    = do_rd && (addr == AW'(OFS_PEER + k)) && be[NB-1];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NBOX; k++) begin
      if (addr == AW'(k))            rd_mux = own_box[k];
      if (addr == AW'(OFS_PEER + k)) rd_mux = peer_box[k];
    end
    if (addr == AW'(OFS_MASK))  rd_mux = DW'(mask);
    if (addr == AW'(OFS_CAUSE)) rd_mux = DW'(cause);
    if (addr == AW'(OFS_STAT))  rd_mux = DW'(pend);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (do_rd) rdata <= rd_mux;
    else            rdata <= '0;
  end

  assert_quiet_rdata_R11: assert property (@(posedge clk) disable iff (rst)
    !(acc && rd) |=> (rdata == '0));
endmodule

// File: rtl/mbx_dual_irq.sv
module mbx_dual_irq #(
  parameter int DW   = 16,
  parameter int NBOX = 4,
  parameter int AW   = 4,
  localparam int NB  = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_mem_en_n,
  input  logic          a_mbx_sel_n,
  input  logic          a_rd,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [NB-1:0] a_be,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_mem_en_n,
  input  logic          b_mbx_sel_n,
  input  logic          b_rd,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  input  logic [NB-1:0] b_be,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  logic [1:0]                     s_en_n, s_sel_n, s_rd, s_wr, s_mask_wr, s_irq;
  logic [1:0][AW-1:0]             s_addr;
  logic [1:0][NB-1:0]             s_be;
  logic [1:0][DW-1:0]             s_wdata, s_rdata;
  logic [1:0][NBOX-1:0][DW-1:0]   s_box;
  logic [1:0][NBOX-1:0]           s_sel, s_raise, s_clr, s_mask, s_cause, s_pend;

  assign s_en_n  = {b_mem_en_n, a_mem_en_n};
  assign s_sel_n = {b_mbx_sel_n, a_mbx_sel_n};
  assign s_rd    = {b_rd, a_rd};
  assign s_wr    = {b_wr, a_wr};
  assign s_addr  = {b_addr, a_addr};
  assign s_be    = {b_be, a_be};
  assign s_wdata = {b_wdata, a_wdata};

  assign a_rdata = s_rdata[0];
  assign b_rdata = s_rdata[1];
  assign a_irq   = s_irq[0];
  assign b_irq   = s_irq[1];

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam int P = 1 - s;

    mbx_port_io #(.DW(DW), .NBOX(NBOX), .AW(AW)) u_io (
      .clk(clk), .rst(rst),
      .mem_en_n(s_en_n[s]), .sel_n(s_sel_n[s]), .rd(s_rd[s]), .wr(s_wr[s]),
      .addr(s_addr[s]), .be(s_be[s]),
      .own_box(s_box[s]), .peer_box(s_box[P]),
      .mask(s_mask[s]), .cause(s_cause[s]), .pend(s_pend[s]),
      .box_sel(s_sel[s]), .raise_peer(s_raise[s]), .clr_own(s_clr[s]),
      .mask_wr(s_mask_wr[s]), .rdata(s_rdata[s])
    );

    mbx_outbox #(.DW(DW), .NBOX(NBOX)) u_box (
      .clk(clk), .rst(rst),
      .box_sel(s_sel[s]), .be(s_be[s]), .wdata(s_wdata[s]),
      .box_q(s_box[s])
    );

    mbx_intr #(.DW(DW), .NBOX(NBOX)) u_irq (
      .clk(clk), .rst(rst),
      .set_src(s_raise[P]), .clr_src(s_clr[s]),
      .mask_wr(s_mask_wr[s]), .wdata(s_wdata[s]),
      .mask_q(s_mask[s]), .pend_q(s_pend[s]), .cause_q(s_cause[s]),
      .irq_q(s_irq[s])
    );
  end
endmodule

// File: tb/mbx_dual_irq_bench.sv
`timescale 1ns/100ps
module mbx_dual_irq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  bit        in_en_n [2];
  bit        in_sel_n[2];
  bit        in_rd   [2];
  bit        in_wr   [2];
  bit [3:0]  in_addr [2];
  bit [1:0]  in_be   [2];
  bit [15:0] in_wd   [2];

  logic [15:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;

  mbx_dual_irq u_mbx_dual_irq (
    .clk(clk), .rst(rst),
    .a_mem_en_n(in_en_n[0]), .a_mbx_sel_n(in_sel_n[0]), .a_rd(in_rd[0]), .a_wr(in_wr[0]),
    .a_addr(in_addr[0]), .a_be(in_be[0]), .a_wdata(in_wd[0]),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_mem_en_n(in_en_n[1]), .b_mbx_sel_n(in_sel_n[1]), .b_rd(in_rd[1]), .b_wr(in_wr[1]),
    .b_addr(in_addr[1]), .b_be(in_be[1]), .b_wdata(in_wd[1]),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  // Reference model state
  bit [15:0] mb[2][4];
  bit [3:0]  m_mask[2], m_pend[2], m_cause[2];
  bit        m_irq[2];
  bit [15:0] m_rd[2];

  int    vectors = 0;
  int    errors  = 0;
  bit    done    = 0;
  string cur_req = "R12";

  task automatic model_step();
    bit [3:0]  set[2], clr[2];
    bit [15:0] rv[2];
    bit        mw[2];
    bit        wflag[2];
    if (rst) begin
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < 4; k++) mb[s][k] = 0;
        m_mask[s] = 0; m_pend[s] = 0; m_cause[s] = 0; m_irq[s] = 0; m_rd[s] = 0;
      end
      return;
    end
    for (int s = 0; s < 2; s++) begin set[s] = 0; clr[s] = 0; rv[s] = 0; mw[s] = 0; wflag[s] = 0; end
    for (int s = 0; s < 2; s++) begin
      int p = 1 - s;
      bit acc = in_en_n[s] && !in_sel_n[s];
      bit w = acc && in_wr[s];
      bit r = acc && in_rd[s] && !in_wr[s];
      int a = in_addr[s];
      wflag[s] = w;
      if (r) begin
        if (a < 4) rv[s] = mb[s][a];
        else if (a == 4) rv[s] = 16'(m_mask[s]);
        else if (a == 5) rv[s] = 16'(m_cause[s]);
        else if (a == 6) rv[s] = 16'(m_pend[s]);
        else if (a >= 8 && a < 12) rv[s] = mb[p][a-8];
        if (a >= 8 && a < 12 && in_be[s][1]) clr[s][a-8] = 1;
      end
      if (w && a < 4 && in_be[s][1]) set[p][a] = 1;
      if (w && a == 4 && in_be[s][0]) mw[s] = 1;
    end
    for (int s = 0; s < 2; s++) begin
      int a = in_addr[s];
      if (wflag[s] && a < 4) begin
        if (in_be[s][0]) mb[s][a][7:0]  = in_wd[s][7:0];
        if (in_be[s][1]) mb[s][a][15:8] = in_wd[s][15:8];
      end
      m_cause[s] = (m_cause[s] & ~clr[s]) | (set[s] & ~m_mask[s]);
      m_pend[s]  = (m_pend[s] & ~clr[s]) | set[s];
      if (mw[s]) m_mask[s] = in_wd[s][3:0];
      m_irq[s] = |(m_pend[s] & ~m_mask[s]);
      m_rd[s]  = rv[s];
    end
  endtask

  task automatic compare();
    logic [15:0] rd_act[2];
    logic        irq_act[2];
    rd_act[0] = a_rdata; rd_act[1] = b_rdata;
    irq_act[0] = a_irq;  irq_act[1] = b_irq;
    for (int s = 0; s < 2; s++) begin
      vectors++;
      if (rd_act[s] !== m_rd[s] || irq_act[s] !== m_irq[s]) begin
        errors++;
        $display("FAIL %s side %0d: rdata=%h irq=%b expected rdata=%h irq=%b",
                 cur_req, s, rd_act[s], irq_act[s], m_rd[s], m_irq[s]);
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  // Explicit check of a value derived directly from a requirement
  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int s);
    in_en_n[s] = 1; in_sel_n[s] = 1; in_rd[s] = 0; in_wr[s] = 0;
    in_addr[s] = 0; in_be[s] = 0; in_wd[s] = 0;
  endtask

  task automatic put(input int s, input bit w, input bit r, input int a,
                     input bit [1:0] be, input bit [15:0] wd);
    in_en_n[s] = 1; in_sel_n[s] = 0; in_wr[s] = w; in_rd[s] = r;
    in_addr[s] = 4'(a); in_be[s] = be; in_wd[s] = wd;
  endtask

  task automatic op(input int s, input bit w, input bit r, input int a,
                    input bit [1:0] be, input bit [15:0] wd);
    put(s, w, r, a, be, wd);
    tick();
    idle(s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(0); idle(1);
    rst = 1;
    repeat (3) tick();
    @(negedge clk) rst = 0;
    cur_req = "R12";
    chk("R12", {15'd0, a_irq}, 16'd0);
    chk("R12", a_rdata, 16'd0);
    op(0, 0, 1, 6, 2'b11, 0);  chk("R12", a_rdata, 16'd0);
    op(1, 0, 1, 4, 2'b11, 0);  chk("R12", b_rdata, 16'd0);

    cur_req = "R3";
    op(0, 1, 0, 1, 2'b01, 16'h0055);            // lower lane only
    chk("R3", {15'd0, b_irq}, 16'd0);
    op(1, 0, 1, 6, 2'b11, 0);  chk("R8", b_rdata, 16'd0);
    op(0, 1, 0, 1, 2'b10, 16'hAA00);            // upper lane raises at B
    chk("R3", {15'd0, b_irq}, 16'd1);
    cur_req = "R2";
    op(0, 0, 1, 1, 2'b11, 0);  chk("R2", a_rdata, 16'hAA55);
    cur_req = "R4";
    op(0, 0, 1, 1, 2'b10, 0);  chk("R4", {15'd0, b_irq}, 16'd1);
    cur_req = "R8";
    op(1, 0, 1, 6, 2'b11, 0);  chk("R8", b_rdata, 16'h0002);

    cur_req = "R5";
    op(1, 0, 1, 9, 2'b01, 0);  chk("R5", {15'd0, b_irq}, 16'd1);
    op(1, 0, 1, 9, 2'b10, 0);  chk("R5", {15'd0, b_irq}, 16'd0);
    chk("R2", b_rdata, 16'hAA55);
    op(1, 0, 1, 9, 2'b11, 0);  chk("R2", b_rdata, 16'hAA55);

    cur_req = "R1";
    in_en_n[0] = 0; in_sel_n[0] = 0; in_wr[0] = 1; in_addr[0] = 2; in_be[0] = 2'b11; in_wd[0] = 16'h1234;
    tick(); idle(0);
    chk("R1", {15'd0, b_irq}, 16'd0);
    op(0, 0, 1, 2, 2'b11, 0);  chk("R1", a_rdata, 16'h0000);
    in_en_n[0] = 0; in_sel_n[0] = 0; in_rd[0] = 1; in_addr[0] = 6;
    tick(); idle(0);
    chk("R1", a_rdata, 16'h0000);

    cur_req = "R6";
    op(1, 1, 0, 4, 2'b01, 16'h0004);            // B masks source 2
    op(0, 0, 1, 4, 2'b11, 0);  chk("R6", a_rdata, 16'h0000);
    cur_req = "R7";
    op(0, 1, 0, 2, 2'b11, 16'hBEEF);
    chk("R9", {15'd0, b_irq}, 16'd0);
    op(1, 0, 1, 6, 2'b11, 0);  chk("R8", b_rdata, 16'h0004);
    op(1, 0, 1, 5, 2'b11, 0);  chk("R7", b_rdata, 16'h0000);
    cur_req = "R9";
    op(1, 1, 0, 4, 2'b01, 16'h0000);            // unmask: irq follows at once
    chk("R9", {15'd0, b_irq}, 16'd1);
    op(1, 0, 1, 5, 2'b11, 0);  chk("R7", b_rdata, 16'h0000);
    op(1, 0, 1, 10, 2'b10, 0); chk("R9", {15'd0, b_irq}, 16'd0);

    cur_req = "R10";
    op(0, 1, 0, 0, 2'b10, 16'h0100);
    put(0, 1, 0, 0, 2'b10, 16'h0200);
    put(1, 0, 1, 8, 2'b10, 0);
    tick(); idle(0); idle(1);
    chk("R10", {15'd0, b_irq}, 16'd1);
    op(1, 0, 1, 5, 2'b11, 0);  chk("R10", b_rdata, 16'h0001);

    cur_req = "R11";
    op(1, 1, 0, 6, 2'b11, 16'h000F);
    op(1, 1, 0, 5, 2'b11, 16'h000F);
    op(1, 0, 1, 6, 2'b11, 0);  chk("R11", b_rdata, 16'h0001);
    tick();                    chk("R11", b_rdata, 16'h0000);
    op(1, 1, 1, 0, 2'b01, 16'h0077);
    chk("R11", b_rdata, 16'h0000);
    op(1, 1, 0, 9, 2'b11, 16'hFFFF);
    op(0, 0, 1, 9, 2'b11, 0);  chk("R11", a_rdata, 16'h0000);

    cur_req = "R3";
    for (int k = 0; k < 4; k++) op(1, 1, 0, k, 2'b10, 16'(k << 12));
    op(0, 0, 1, 6, 2'b11, 0);  chk("R3", a_rdata, 16'h000F);
    cur_req = "R7";
    op(0, 0, 1, 5, 2'b11, 0);  chk("R7", a_rdata, 16'h000F);
    cur_req = "R5";
    for (int k = 0; k < 4; k++) op(0, 0, 1, 8 + k, 2'b10, 0);
    chk("R5", {15'd0, a_irq}, 16'd0);
    op(0, 0, 1, 5, 2'b11, 0);  chk("R7", a_rdata, 16'h0000);

    cur_req = "R12";
    rst = 1; tick(); @(negedge clk) rst = 0;
    op(0, 0, 1, 8, 2'b11, 0);  chk("R12", a_rdata, 16'h0000);
    repeat (3) tick();
    finish_run();
  end
endmodule